// File: doc/BRIEF.md
# Indirect Byte Access Port for Non-Volatile Memory

The block gives host software byte access to a 64K-byte non-volatile memory through one 32-bit control/status register. Software places a 3-bit command in the top three bits of the register and a byte in the data field. The command either loads one half of a 16-bit address, or starts a write or a read at the address that is loaded. The block keeps the address, runs the access over a request/acknowledge pair on its memory side, and shows a busy flag while the access runs. When a read ends, the fetched byte appears in the data field.

Software writes the register through byte-lane enables. It normally writes the command lane (bits 31-24) and then the data lane (bits 23-16) as two separate writes. The block also accepts both lanes in a single 32-bit write. Software polls the busy bit until it clears before it reads the result or issues the next begin command.

Top module: `nvram_port`

## Requirements
- R1: After reset, the register reads 0x0000_0000 and no memory request is pending.
- R2: Command 100 (bits 31-29), written to the command lane (byte enable bit 3), arms a low-address load. The next write to the data lane (byte enable bit 2) stores bits 23-16 as address bits 7-0.
- R3: Command 101 arms a high-address load in the same way. The data-lane byte becomes address bits 15-8.
- R4: Command 110 starts a write to the loaded address. The byte written is bits 23-16 when the data lane is enabled in the same write, and the current data-field byte otherwise. Once the access completes, the byte is stored at that address.
- R5: Command 111 starts a read from the loaded address. When the access completes, the fetched byte reads back in bits 23-16.
- R6: Bit 31 reads 1 from the cycle after a begin command until the cycle after the memory acknowledge. It reads 0 otherwise.
- R7: A command with bit 31 clear (000 to 011) starts nothing, does not arm a load, and does not cancel a load that is already armed.
- R8: While busy, command-lane and data-lane writes are ignored. The address, the data field and the memory request stay unchanged.
- R9: A load takes effect with the data byte either in the same 32-bit write as its command or in a later data-lane write.
- R10: Register bits 30-24 and 15-0 always read as zero.
- R11: The memory request stays high until it is acknowledged. Address, write enable and write data stay stable during that time, and each begin command raises exactly one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_be_i | input | 4 | Byte-lane enables of the register write |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read value: busy, data field |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 16 | Byte address of the access |
| mem_wdata_o | output | 8 | Byte to store |
| mem_rdata_i | input | 8 | Byte fetched, valid with acknowledge |
| mem_ack_i | input | 1 | Memory acknowledge, ends the access |

## Verification
The bench builds the block with its default widths: a 32-bit register, an 8-bit data byte and a 16-bit address in two halves. With these widths, every address used, such as 0x1234 and 0xAB56, tells the two halves apart. The memory model's acknowledge latency is a run-time value of the bench. It is set to 1, 3, 4 and 5 cycles, so the busy window is measured both at its shortest and when it is long enough to issue ignored writes while busy. Unwritten memory locations return a byte that depends on both address halves, so a load that fails or lands in the wrong half shows up as a wrong read value.

// File: rtl/nvp_pkg.sv
package nvp_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned ADDR_BYTES = 2;
  localparam int unsigned ADDR_W     = BYTE_W * ADDR_BYTES;
  localparam int unsigned LANES      = REG_W / BYTE_W;
  localparam int unsigned CMD_W      = 3;
  localparam int unsigned CMD_LSB    = REG_W - CMD_W;
  localparam int unsigned DAT_LSB    = 16;
  localparam int unsigned CMD_LANE   = 3;
  localparam int unsigned DAT_LANE   = DAT_LSB / BYTE_W;

  typedef enum logic [CMD_W-1:0] {
    CMD_LD_LO = 3'b100,
    CMD_LD_HI = 3'b101,
    CMD_WR    = 3'b110,
    CMD_RD    = 3'b111
  } cmd_e;

  typedef struct packed {
    logic              vld;
    logic              we;
    logic [BYTE_W-1:0] data;
  } start_t;
endpackage

// File: rtl/nvp_decode.sv
module nvp_decode
  import nvp_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [LANES-1:0]      be_i,
  input  logic [REG_W-1:0]      wdata_i,
  input  logic                  busy_i,
  input  logic                  rd_done_i,
  input  logic [BYTE_W-1:0]     rd_byte_i,
  output logic [ADDR_BYTES-1:0] load_o,
  output logic [BYTE_W-1:0]     addr_byte_o,
  output start_t                start_o,
  output logic [BYTE_W-1:0]     data_o
);
  logic [CMD_W-1:0]  cmd;
  logic [BYTE_W-1:0] byte_in;
  logic              cmd_wr, dat_wr, is_load;
  logic              pend_v_q, pend_hi_q;
  logic              eff_v, eff_hi;
  logic [BYTE_W-1:0] data_q;

  assign cmd     = wdata_i[CMD_LSB +: CMD_W];
  assign byte_in = wdata_i[DAT_LSB +: BYTE_W];
  // top command bit clear: not a command
  assign cmd_wr  = we_i & be_i[CMD_LANE] & ~busy_i & cmd[CMD_W-1];
  assign dat_wr  = we_i & be_i[DAT_LANE] & ~busy_i;
  assign is_load = (cmd == CMD_LD_LO) || (cmd == CMD_LD_HI);

  // a command in the same write overrides the armed load
  assign eff_v  = cmd_wr ? is_load : pend_v_q;
  assign eff_hi = cmd_wr ? cmd[0]  : pend_hi_q;

  for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_load
    assign load_o[i] = dat_wr & eff_v & (eff_hi == 1'(i));
  end
  assign addr_byte_o = byte_in;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_q  <= 1'b0;
      pend_hi_q <= 1'b0;
    end else if (dat_wr && eff_v) begin
      pend_v_q  <= 1'b0;
    end else if (cmd_wr) begin
      pend_v_q  <= is_load;
      pend_hi_q <= cmd[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        data_q <= '0;
    else if (rd_done_i) data_q <= rd_byte_i;
    else if (dat_wr)    data_q <= byte_in;
  end

  assign start_o.vld  = cmd_wr & ~is_load;
  assign start_o.we   = (cmd == CMD_WR);
  assign start_o.data = be_i[DAT_LANE] ? byte_in : data_q;
  assign data_o       = data_q;

  p_busy_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !rd_done_i |=> data_o == $past(data_o));
  p_one_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load_o));
endmodule

// File: rtl/nvp_addr.sv
module nvp_addr
  import nvp_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_BYTES-1:0] load_i,
  input  logic [BYTE_W-1:0]     byte_i,
  output logic [ADDR_W-1:0]     addr_o
);
  for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_byte
    logic [BYTE_W-1:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        byte_q <= '0;
      else if (load_i[i]) byte_q <= byte_i;
    end
    assign addr_o[i*BYTE_W +: BYTE_W] = byte_q;
  end

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i == '0 |=> $stable(addr_o));
endmodule

// File: rtl/nvp_seq.sv
module nvp_seq
  import nvp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  start_t            start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mem_ack_i,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              busy_o,
  output logic              rd_done_o,
  output logic [BYTE_W-1:0] rd_byte_o
);
  logic              req_q, we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (!req_q) begin
      if (start_i.vld) begin
        req_q   <= 1'b1;
        we_q    <= start_i.we;
        addr_q  <= addr_i;
        wdata_q <= start_i.data;
      end
    end else if (mem_ack_i) begin
      req_q <= 1'b0;
    end
  end

  assign mem_req_o   = req_q;
  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign busy_o      = req_q;
  assign rd_done_o   = req_q & mem_ack_i & ~we_q;
  assign rd_byte_o   = mem_rdata_i;

  p_req_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
                                && $stable(mem_we_o) && $stable(mem_wdata_o));
  p_start_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i.vld && !busy_o |=> mem_req_o);
  p_ack_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i |=> !mem_req_o);
endmodule

// File: rtl/nvram_port.sv
module nvram_port
  import nvp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [3:0]        reg_be_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [15:0]       mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  input  logic              mem_ack_i
);
  logic [ADDR_BYTES-1:0] load;
  logic [BYTE_W-1:0]     addr_byte, data, rd_byte;
  logic [ADDR_W-1:0]     addr;
  logic                  busy, rd_done;
  start_t                start;

  nvp_decode i_decode (
    .clk_i, .rst_ni,
    .we_i        (reg_we_i),
    .be_i        (reg_be_i),
    .wdata_i     (reg_wdata_i),
    .busy_i      (busy),
    .rd_done_i   (rd_done),
    .rd_byte_i   (rd_byte),
    .load_o      (load),
    .addr_byte_o (addr_byte),
    .start_o     (start),
    .data_o      (data)
  );

  nvp_addr i_addr (
    .clk_i, .rst_ni,
    .load_i (load),
    .byte_i (addr_byte),
    .addr_o (addr)
  );

  nvp_seq i_seq (
    .clk_i, .rst_ni,
    .start_i     (start),
    .addr_i      (addr),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .busy_o      (busy),
    .rd_done_o   (rd_done),
    .rd_byte_o   (rd_byte)
  );

  always_comb begin
    reg_rdata_o                       = '0;
    reg_rdata_o[REG_W-1]              = busy;
    reg_rdata_o[DAT_LSB +: BYTE_W]    = data;
  end

  p_rd_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i && !mem_we_o |=> reg_rdata_o[23:16] == $past(mem_rdata_i));
  p_busy_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && reg_we_i |=> $stable(addr));
  p_low_cmd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_be_i[3] && !reg_wdata_i[31] && !mem_req_o |=> !mem_req_o);
endmodule

// File: tb/test_nvram_port.sv
module test_nvram_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  be = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic        mreq, mwe, mack;
  logic [15:0] maddr;
  logic [7:0]  mwdata, mrdata;

  int n_chk = 0, n_fail = 0;
  int lat = 3;
  int mcnt = 0;
  int req_rises = 0;
  int hold_viol = 0;
  int cyc = 0;
  logic [7:0] mem [logic [15:0]];

  always #2 clk = ~clk;

  nvram_port i_nvram_port (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_be_i(be), .reg_wdata_i(wd), .reg_rdata_o(rdata),
    .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr), .mem_wdata_o(mwdata),
    .mem_rdata_i(mrdata), .mem_ack_i(mack)
  );

  function automatic logic [7:0] dflt(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  assign mrdata = mem.exists(maddr) ? mem[maddr] : dflt(maddr);

  // memory model: acknowledge after lat cycles of request
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mack <= 1'b0;
      mcnt <= 0;
    end else begin
      mack <= 1'b0;
      if (mreq && !mack) begin
        if (mcnt >= lat - 1) begin
          mack <= 1'b1;
          mcnt <= 0;
          if (mwe) mem[maddr] = mwdata;
        end else begin
          mcnt <= mcnt + 1;
        end
      end
    end
  end

  // R11 monitor
  logic        p_req = 1'b0, p_ack = 1'b0, p_we = 1'b0;
  logic [15:0] p_addr = '0;
  logic [7:0]  p_wd = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mreq && !p_req) req_rises++;
      if (p_req && !p_ack && (!mreq || maddr != p_addr || mwe != p_we || mwdata != p_wd))
        hold_viol++;
    end
    p_req = mreq; p_ack = mack; p_addr = maddr; p_we = mwe; p_wd = mwdata;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; be = b; wd = d;
    @(negedge clk);
    we = 1'b0; be = '0; wd = '0;
  endtask

  task automatic wait_idle(output int cycles);
    cycles = 0;
    while (rdata[31] && cycles < 200) begin
      cycles++;
      @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic        chk;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [7:0]  exp;
  } vec_t;
  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'h8, 32'h8000_0000, 8'h00},  // R2 split load low
    '{1'b0, 4'h4, 32'h0034_0000, 8'h00},
    '{1'b0, 4'h8, 32'hA000_0000, 8'h00},  // R3 split load high
    '{1'b0, 4'h4, 32'h0012_0000, 8'h00},
    '{1'b0, 4'h8, 32'hE000_0000, 8'h00},  // R5 read 0x1234
    '{1'b1, 4'h0, 32'h0,         8'h83},
    '{1'b0, 4'hC, 32'h8056_0000, 8'h00},  // R9 combined loads
    '{1'b0, 4'hC, 32'hA0AB_0000, 8'h00},
    '{1'b0, 4'hC, 32'hC03C_0000, 8'h00},  // R4 write 0x3C to 0xAB56
    '{1'b1, 4'h0, 32'h0,         8'h3C},
    '{1'b0, 4'h8, 32'hE000_0000, 8'h00},
    '{1'b1, 4'h0, 32'h0,         8'h3C},  // R4 stored, default would be 58
    '{1'b0, 4'h8, 32'h2000_0000, 8'h00},  // R7 ignored, must not arm
    '{1'b0, 4'h4, 32'h0077_0000, 8'h00},
    '{1'b0, 4'h8, 32'hE000_0000, 8'h00},
    '{1'b1, 4'h0, 32'h0,         8'h3C},
    '{1'b0, 4'h8, 32'h8000_0000, 8'h00},  // R7 armed load survives 011
    '{1'b0, 4'h8, 32'h6000_0000, 8'h00},
    '{1'b0, 4'h4, 32'h0010_0000, 8'h00},
    '{1'b0, 4'h8, 32'hE000_0000, 8'h00},
    '{1'b1, 4'h0, 32'h0,         8'h1E}   // 0xAB10
  };

  initial begin
    int c, r0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rdata == 32'h0, "R1 register after reset", rdata, 32'h0);
    check(!mreq, "R1 request after reset", {31'h0, mreq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (!VEC[i].chk) reg_write(VEC[i].be, VEC[i].wd);
      else begin
        wait_idle(c);
        check(rdata[23:16] == VEC[i].exp,
              $sformatf("R2/R3/R4/R5/R7/R9 vector %0d", i),
              {24'h0, rdata[23:16]}, {24'h0, VEC[i].exp});
      end
    end

    // R7 low command starts nothing
    r0 = req_rises;
    reg_write(4'h8, 32'h6000_0000);
    check(!rdata[31] && !mreq && req_rises == r0, "R7 no start", rdata, 32'h0);

    // R6 busy window for two latencies
    lat = 1;
    reg_write(4'h8, 32'hE000_0000);
    wait_idle(c);
    check(c == 2, "R6 busy cycles lat 1", c, 2);
    lat = 5;
    reg_write(4'h8, 32'hE000_0000);
    check((rdata & 32'h7F00_FFFF) == 0, "R10 zero bits while busy", rdata, 32'h0);
    wait_idle(c);
    check(c == 6, "R6 busy cycles lat 5", c, 6);
    check((rdata & 32'h7F00_FFFF) == 0, "R10 zero bits idle", rdata, 32'h0);

    // R8 writes while busy are ignored
    lat = 4;
    reg_write(4'hC, 32'h8034_0000);
    reg_write(4'hC, 32'hA012_0000);
    r0 = req_rises;
    reg_write(4'h8, 32'hE000_0000);
    reg_write(4'hC, 32'h8099_0000);
    reg_write(4'hC, 32'hC0EE_0000);
    wait_idle(c);
    check(rdata[23:16] == 8'h83, "R8 data after busy writes", rdata[23:16], 8'h83);
    check(req_rises == r0 + 1, "R8 one request", req_rises, r0 + 1);
    reg_write(4'h8, 32'hE000_0000);
    wait_idle(c);
    check(rdata[23:16] == 8'h83, "R8 address unchanged", rdata[23:16], 8'h83);
    check(!mem.exists(16'h1299) && !mem.exists(16'h1234), "R8 no write stored",
          32'h0, 32'h0);

    // R4 begin write from data field without data lane
    lat = 3;
    reg_write(4'h4, 32'h005A_0000);
    reg_write(4'h8, 32'hC000_0000);
    wait_idle(c);
    reg_write(4'h8, 32'hE000_0000);
    wait_idle(c);
    check(rdata[23:16] == 8'h5A, "R4 write from data field", rdata[23:16], 8'h5A);

    check(hold_viol == 0, "R11 request hold", hold_viol, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule